// File: doc/BRIEF.md
# Numerically Controlled IQ Tone Generator

This block produces a continuous sampled sine wave for an 8-bit DAC. A phase accumulator advances by a programmed frequency word on every clock. A signed in-phase and a signed quadrature coefficient form a vector, and a pipelined CORDIC rotator turns that vector by the carrier phase. The rotated in-phase component is rounded, added to an unsigned midpoint and clamped to the 8-bit range. One sample leaves the block on each clock.

Software programs the frequency, the two coefficients and the midpoint through a small write port. The tone then runs unattended until the next write. A new frequency word changes the pitch at once, and the accumulator carries on from the phase it had reached. The CORDIC gain of about 1.647 is not corrected inside the block. Software folds it into the coefficients by scaling them by roughly 1000/1646.

Top module: `iq_tone_gen`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and sample_o is 0. Exactly ITER+3 clocks after reset is released, valid_o rises. After that it stays high, and one sample is produced per clock.
- R2: Writes use wr_addr_i. Address 0 loads the frequency word. Address 1 loads the I word: the I coefficient is in bits [31:24] and the unsigned midpoint in bits [7:0]. Address 2 loads the Q word, with the Q coefficient in bits [31:24]. Bits [23:8] of the I word, bits [23:0] of the Q word and any write to address 3 have no effect. After reset the frequency is 0, I and Q are 0 and the midpoint is 128.
- R3: I and Q are 8-bit two's complement. For example, 0xC4 acts as -60 and not as 196.
- R4: sample_o equals midpoint + round(K·(I·cosθ − Q·sinθ)) to within ±2 LSB. K is about 1.647, and θ is the phase held in the top bits of the accumulator (a full turn is 2^32).
- R5: The phase advances by the frequency word every clock, so the tone frequency is word/2^32 of the clock rate. Word 0x40000000 gives a period of exactly 4 samples, and 0x20000000 gives exactly 8.
- R6: Writing a new frequency word never resets the accumulator. Running word 0x40000000 for N clocks and then writing 0 freezes the phase at N quarter turns.
- R7: When midpoint plus the rotated value falls outside 0..255, the output is clamped to 0 or 255.
- R8: When I = Q = 0, sample_o holds exactly the midpoint for any frequency word.
- R9: When no write occurs, the block keeps producing the last programmed tone. With frequency word 0, sample_o stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System and sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Write data |
| sample_o | output | 8 | Unsigned DAC sample |
| valid_o | output | 1 | Sample valid, held high once the pipeline is full |

## Verification
The checker keeps a shadow copy of every write so it knows the programmed frequency, coefficients and midpoint. It judges the output only after ITER+5 clocks have passed with no write, so that no sample from before the last change is still in the pipeline. The stimulus follows that rule: each test that checks a settled value waits about thirty clocks after its last write. Phase-dependent results are measured only at a frozen phase or across whole periods. Tests that depend on phase start from a fresh reset, so the accumulator begins at zero.

// File: rtl/iq_tone_pkg.sv
package iq_tone_pkg;
  localparam int REG_W = 32;
  localparam int COEF_W = 8;
  localparam int ANG_W = 16;  // full turn = 2**16, angle table is scaled to this

  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_IWORD = 2'd1,
    SEL_QWORD = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // atan(2^-k) in units of 2**16 per turn
  function automatic logic [ANG_W-1:0] atan_step(input int k);
    case (k)
      0:       atan_step = 16'd8192;
      1:       atan_step = 16'd4836;
      2:       atan_step = 16'd2555;
      3:       atan_step = 16'd1297;
      4:       atan_step = 16'd651;
      5:       atan_step = 16'd326;
      6:       atan_step = 16'd163;
      7:       atan_step = 16'd81;
      8:       atan_step = 16'd41;
      9:       atan_step = 16'd20;
      10:      atan_step = 16'd10;
      11:      atan_step = 16'd5;
      12:      atan_step = 16'd3;
      13:      atan_step = 16'd1;
      14:      atan_step = 16'd1;
      default: atan_step = 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import iq_tone_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter logic [7:0] OFS_RST = 8'd128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_addr_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output logic [ACC_W-1:0]         freq_o,
  output logic [COEF_W-1:0]        i_coef_o,
  output logic [COEF_W-1:0]        q_coef_o,
  output logic [7:0]               ofs_o
);
  localparam int CF_LSB = REG_W - COEF_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o   <= '0;
      i_coef_o <= '0;
      q_coef_o <= '0;
      ofs_o    <= OFS_RST;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_addr_i))
        SEL_FREQ:  freq_o <= ACC_W'(wr_data_i);
        SEL_IWORD: begin
          i_coef_o <= wr_data_i[REG_W-1:CF_LSB];
          ofs_o    <= wr_data_i[7:0];
        end
        SEL_QWORD: q_coef_o <= wr_data_i[REG_W-1:CF_LSB];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc
  import iq_tone_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  output logic [ANG_W-1:0] ang_o
);
  logic [ACC_W-1:0] phase_q;

  // never cleared by a frequency write: phase stays continuous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + freq_i;
  end

  assign ang_o = phase_q[ACC_W-1 -: ANG_W];
endmodule

// File: rtl/tone_cordic.sv
module tone_cordic
  import iq_tone_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 6,
  parameter int ITER = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ANG_W-1:0]     ang_i,
  input  logic [COEF_W-1:0]    i_coef_i,
  input  logic [COEF_W-1:0]    q_coef_i,
  output logic signed [DW-1:0] x_o
);
  localparam int EXT = DW - COEF_W - FRAC;

  logic signed [DW-1:0]    i_ext, q_ext, x_pre, y_pre;
  logic signed [ANG_W-1:0] z_pre;
  logic signed [DW-1:0]    x_s [ITER];
  logic signed [DW-1:0]    y_s [ITER];
  logic signed [ANG_W-1:0] z_s [ITER];

  // explicit two's complement sign extension of the byte coefficients
  assign i_ext = {{EXT{i_coef_i[COEF_W-1]}}, i_coef_i, {FRAC{1'b0}}};
  assign q_ext = {{EXT{q_coef_i[COEF_W-1]}}, q_coef_i, {FRAC{1'b0}}};

  // quadrant pre-rotation, residual angle in [0, quarter turn)
  always_comb begin
    z_pre = {2'b00, ang_i[ANG_W-3:0]};
    case (ang_i[ANG_W-1 -: 2])
      2'd0:    begin x_pre = i_ext;  y_pre = q_ext;  end
      2'd1:    begin x_pre = -q_ext; y_pre = i_ext;  end
      2'd2:    begin x_pre = -i_ext; y_pre = -q_ext; end
      default: begin x_pre = q_ext;  y_pre = -i_ext; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ITER; k++) begin
        x_s[k] <= '0;
        y_s[k] <= '0;
        z_s[k] <= '0;
      end
      x_o <= '0;
    end else begin
      x_s[0] <= x_pre;
      y_s[0] <= y_pre;
      z_s[0] <= z_pre;
      for (int k = 0; k < ITER - 1; k++) begin
        if (!z_s[k][ANG_W-1]) begin
          x_s[k+1] <= x_s[k] - (y_s[k] >>> k);
          y_s[k+1] <= y_s[k] + (x_s[k] >>> k);
          z_s[k+1] <= z_s[k] - signed'(atan_step(k));
        end else begin
          x_s[k+1] <= x_s[k] + (y_s[k] >>> k);
          y_s[k+1] <= y_s[k] - (x_s[k] >>> k);
          z_s[k+1] <= z_s[k] + signed'(atan_step(k));
        end
      end
      if (!z_s[ITER-1][ANG_W-1]) x_o <= x_s[ITER-1] - (y_s[ITER-1] >>> (ITER - 1));
      else                       x_o <= x_s[ITER-1] + (y_s[ITER-1] >>> (ITER - 1));
    end
  end
endmodule

// File: rtl/tone_out_stage.sv
module tone_out_stage #(
  parameter int DW   = 16,
  parameter int FRAC = 6,
  parameter int LAT  = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  input  logic [7:0]           ofs_i,
  output logic [7:0]           sample_o,
  output logic                 valid_o
);
  logic signed [DW-1:0] x_rnd;
  logic signed [DW:0]   sum;
  logic [7:0]           sat;
  logic [LAT-1:0]       fill_q;

  assign x_rnd = (x_i + DW'(1 << (FRAC - 1))) >>> FRAC;
  assign sum   = $signed({{(DW-8){1'b0}}, ofs_i}) + (DW+1)'(x_rnd);

  always_comb begin
    if (sum < 0)                        sat = 8'd0;
    else if (sum > $signed((DW+1)'(255))) sat = 8'd255;
    else                                sat = sum[7:0];
  end

  generate
    if (LAT > 1) begin : g_fill
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fill_q <= '0;
        else         fill_q <= {fill_q[LAT-2:0], 1'b1};
      end
    end else begin : g_fill1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fill_q <= '0;
        else         fill_q <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= fill_q[LAT-1] ? sat : 8'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= fill_q[LAT-1];
  end
endmodule

// File: rtl/iq_tone_gen.sv
module iq_tone_gen
  import iq_tone_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int DW    = 16,
  parameter int FRAC  = 6,
  parameter int ITER  = 12,
  parameter logic [7:0] OFS_RST = 8'd128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  output logic [7:0]  sample_o,
  output logic        valid_o
);
  // accumulator, pre-rotation and ITER stages before the output register
  localparam int FILL = ITER + 2;

  logic [ACC_W-1:0]     freq;
  logic [COEF_W-1:0]    i_coef, q_coef;
  logic [7:0]           ofs;
  logic [ANG_W-1:0]     ang;
  logic signed [DW-1:0] x_rot;

  tone_regs #(.ACC_W(ACC_W), .OFS_RST(OFS_RST)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .freq_o(freq), .i_coef_o(i_coef), .q_coef_o(q_coef), .ofs_o(ofs)
  );

  tone_phase_acc #(.ACC_W(ACC_W)) i_acc (
    .clk_i, .rst_ni, .freq_i(freq), .ang_o(ang)
  );

  tone_cordic #(.DW(DW), .FRAC(FRAC), .ITER(ITER)) i_cordic (
    .clk_i, .rst_ni, .ang_i(ang), .i_coef_i(i_coef), .q_coef_i(q_coef), .x_o(x_rot)
  );

  tone_out_stage #(.DW(DW), .FRAC(FRAC), .LAT(FILL)) i_out (
    .clk_i, .rst_ni, .x_i(x_rot), .ofs_i(ofs), .sample_o, .valid_o
  );
endmodule

// File: rtl/iq_tone_chk.sv
module iq_tone_chk #(
  parameter int ITER = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic [7:0]  sample_o,
  input logic        valid_o
);
  localparam int SETTLE = ITER + 5;
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] quiet_cnt;
  logic          f_zero, i_zero, q_zero;
  logic [7:0]    ofs_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_cnt <= '0;
      f_zero    <= 1'b1;
      i_zero    <= 1'b1;
      q_zero    <= 1'b1;
      ofs_sh    <= 8'd128;
    end else if (wr_en_i) begin
      quiet_cnt <= '0;
      case (wr_addr_i)
        2'd0: f_zero <= (wr_data_i == 32'd0);
        2'd1: begin i_zero <= (wr_data_i[31:24] == 8'd0); ofs_sh <= wr_data_i[7:0]; end
        2'd2: q_zero <= (wr_data_i[31:24] == 8'd0);
        default: ;
      endcase
    end else if (quiet_cnt != CW'(SETTLE)) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R1
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> sample_o == 8'd0);

  // R8
  zero_coef_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt == CW'(SETTLE) && i_zero && q_zero) |-> sample_o == ofs_sh);

  // R9
  frozen_tone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt == CW'(SETTLE) && f_zero) |-> $stable(sample_o));

  // R1
  settled_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt == CW'(SETTLE)) |-> valid_o);
endmodule

bind iq_tone_gen iq_tone_chk #(.ITER(ITER)) i_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .sample_o, .valid_o
);

// File: tb/test_iq_tone_gen.sv
module test_iq_tone_gen;
  localparam int  ITER = 12;
  localparam real KG = 1.64676;
  localparam real PI = 3.14159265358979;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  sample_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] buf8 [16];

  always #2.5 clk_i = ~clk_i;

  iq_tone_gen #(.ITER(ITER)) i_iq_tone_gen (.*);

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    n_chk++;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  function automatic int model(input int ofs, input int i, input int q, input real deg);
    real v;
    int r;
    v = ofs + KG * (i * $cos(deg * PI / 180.0) - q * $sin(deg * PI / 180.0));
    r = $rtoi(v + 1000.5) - 1000;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 valid in reset", valid_o, 0, 0);
    check("R1 sample in reset", sample_o, 0, 0);
    rst_ni = 1'b1;
    repeat (ITER + 2) @(negedge clk_i);
    check("R1 valid before fill", valid_o, 0, 0);
    @(negedge clk_i);
    check("R1 valid after ITER+3", valid_o, 1, 0);
    settle();
    check("R2 reset midpoint", sample_o, 128, 0);
    check("R1 valid stays", valid_o, 1, 0);
  endtask

  task automatic t_zero_coef();
    do_reset();
    wr(2'd1, 32'h0000_005A);
    wr(2'd0, 32'h1357_2468);
    settle();
    for (int k = 0; k < 16; k++) begin
      check("R8 zero coef midpoint", sample_o, 8'h5A, 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_amp_and_map();
    do_reset();
    wr(2'd1, {8'd60, 16'h0000, 8'd128});
    settle();
    check("R4 gain at phase 0", sample_o, model(128, 60, 0, 0.0), 2);
    wr(2'd1, {8'd60, 16'hABCD, 8'd128});
    settle();
    check("R2 middle bytes ignored", sample_o, model(128, 60, 0, 0.0), 2);
    wr(2'd3, 32'hFFFF_FFFF);
    settle();
    check("R2 address 3 ignored", sample_o, model(128, 60, 0, 0.0), 2);
    wr(2'd2, 32'h0012_3456);
    settle();
    check("R2 Q low bytes ignored", sample_o, model(128, 60, 0, 0.0), 2);
    wr(2'd1, {8'hC4, 16'h0000, 8'd128});
    settle();
    check("R3 negative I", sample_o, model(128, -60, 0, 0.0), 2);
  endtask

  task automatic t_saturate();
    do_reset();
    wr(2'd1, {8'd127, 16'h0000, 8'd200});
    settle();
    check("R7 clamp high", sample_o, 255, 0);
    wr(2'd1, {8'h80, 16'h0000, 8'd20});
    settle();
    check("R7 clamp low", sample_o, 0, 0);
  endtask

  // run a quarter-turn word for n clocks, then stop
  task automatic freeze_after(input int n);
    wr(2'd0, 32'h4000_0000);
    repeat (n - 1) @(negedge clk_i);
    wr(2'd0, 32'h0000_0000);
    settle();
  endtask

  task automatic t_phase_cont();
    do_reset();
    wr(2'd1, {8'd60, 16'h0000, 8'd128});
    freeze_after(6);
    check("R6 phase kept at 180 deg", sample_o, model(128, 60, 0, 180.0), 2);
    do_reset();
    wr(2'd2, {8'd60, 24'h0});
    freeze_after(5);
    check("R4 Q term at 90 deg", sample_o, model(128, 0, 60, 90.0), 2);
    do_reset();
    wr(2'd2, {8'd60, 24'h0});
    freeze_after(7);
    check("R6 Q term at 270 deg", sample_o, model(128, 0, 60, 270.0), 2);
  endtask

  task automatic t_freq();
    int mx;
    do_reset();
    wr(2'd1, {8'd60, 16'h0000, 8'd128});
    wr(2'd0, 32'h4000_0000);
    settle();
    for (int k = 0; k < 8; k++) begin
      buf8[k] = sample_o;
      @(negedge clk_i);
    end
    for (int k = 0; k < 4; k++) check("R5 period 4", buf8[k+4], buf8[k], 0);
    for (int k = 0; k < 2; k++) check("R5 half period mirror", buf8[k+2], 256 - buf8[k], 2);
    wr(2'd0, 32'h2000_0000);
    settle();
    mx = 0;
    for (int k = 0; k < 16; k++) begin
      buf8[k] = sample_o;
      if (sample_o > mx) mx = sample_o;
      @(negedge clk_i);
    end
    for (int k = 0; k < 8; k++) check("R5 period 8 after change", buf8[k+8], buf8[k], 0);
    for (int k = 0; k < 4; k++) check("R5 period 8 mirror", buf8[k+4], 256 - buf8[k], 2);
    check("R4 peak at period 8", mx, model(128, 60, 0, 0.0), 2);
    check("R9 valid during tone", valid_o, 1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_zero_coef();
        t_amp_and_map();
        t_saturate();
        t_phase_cont();
        t_freq();
      end
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule